// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns sixteen external signal lines into interrupt requests for a processor. Each line N watches pin N of one of up to seven general-purpose input ports; a 4-bit selector per line picks which port. The chosen pin is brought into the clock domain through a two-flop synchronizer. A registered copy of its previous value is used to detect rising and falling edges. Rising and falling detection are enabled separately for each line.

A qualifying edge latches a pending flag for its line. Software can also raise a pending flag by writing a software-request register. A pending flag is cleared by writing a 1 to its bit. An interrupt mask decides which pending flags reach the request outputs. The sixteen lines are folded onto seven level-sensitive request outputs. A separate event mask produces a one-cycle event pulse per line, independent of the interrupt mask.

Configuration uses a simple register bus: one cycle per write, with read data returned combinationally in the same cycle as the read request.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `event_o` is 0.
- R2: Register offsets are 0x00 interrupt mask, 0x04 event mask, 0x08 rising enable, 0x0C falling enable, 0x10 software request, 0x14 pending, and 0x18/0x1C/0x20/0x24 port select for lines 0-3/4-7/8-11/12-15. Line registers use bits [15:0]. A select register holds four 4-bit fields in bits [15:0], with line N in bits [4*(N%4)+3:4*(N%4)]. Unused upper bits and unmapped offsets read 0.
- R3: With its rising enable bit set, a 0-to-1 change on a line's selected pin, applied before clock edge k, sets that line's pending bit after edge k+2.
- R4: With its falling enable bit set, a 1-to-0 change sets the pending bit with the same latency. With both enable bits set, either edge sets it. With neither set, no edge sets it.
- R5: Pending bits are set regardless of the interrupt mask. A request output is high only while one of its lines has both its pending bit and its interrupt mask bit set.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: If an enabled edge and a clear of the same pending bit land on the same clock edge, the bit stays set.
- R8: Writing 1 to a software request bit sets that bit and the matching pending bit on the next edge. Clearing the pending bit also clears the software request bit.
- R9: When the event mask bit is set, an enabled edge drives `event_o[N]` high for exactly one cycle, after edge k+2. This happens regardless of the interrupt mask. With the event mask bit clear, no pulse occurs.
- R10: `irq_o[0..4]` follow lines 0..4 one to one. `irq_o[5]` is the OR of lines 5-9. `irq_o[6]` is the OR of lines 10-15.
- R11: Port code p in 0..6 selects bit p*16+N of `port_pins_i` for line N. Codes 7-15 select a constant 0, so no edge ever occurs on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_pins_i | input | 112 | Seven 16-bit input ports, port p at bits [16p+15:16p] |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_o | output | 7 | Level interrupt requests |
| event_o | output | 16 | One-cycle event pulses per line |

## Verification
A wrong pending bit appears on the request output of its group in the same cycle and can be read back through the pending register. The checks therefore sample both, on the exact cycle after the third clock edge following a pin change. A synchronizer or edge stage that is too short or too long moves the pending bit and the event pulse one cycle early or late, and the cycle-exact checks catch that. A wrong select decode shows up as a pending bit that never appears, or one that appears on the wrong line.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned OFF_IMASK = 'h00;
  localparam int unsigned OFF_EMASK = 'h04;
  localparam int unsigned OFF_RISE  = 'h08;
  localparam int unsigned OFF_FALL  = 'h0C;
  localparam int unsigned OFF_SWREQ = 'h10;
  localparam int unsigned OFF_PEND  = 'h14;
  localparam int unsigned OFF_SEL0  = 'h18;
  localparam int unsigned REG_STEP  = 4;
endpackage

// File: rtl/eic_port_mux.sv
module eic_port_mux #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_PORTS = 7,
  parameter int unsigned SEL_W     = 4
) (
  input  logic [NUM_PORTS*NUM_LINES-1:0] pins_i,
  input  logic [NUM_LINES*SEL_W-1:0]     sel_i,
  output logic [NUM_LINES-1:0]           line_o
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [SEL_W-1:0] code;
    assign code = sel_i[n*SEL_W +: SEL_W];
    always_comb begin
      line_o[n] = 1'b0;  // unused codes give constant 0
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (code == SEL_W'(p)) line_o[n] = pins_i[p*NUM_LINES + n];
      end
    end
  end
endmodule

// File: rtl/eic_edge_det.sv
module eic_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= in_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise_o = sync2_q & ~prev_q;
  assign fall_o = ~sync2_q & prev_q;
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int unsigned NUM_LINES      = 16,
  parameter int unsigned SEL_W          = 4,
  parameter int unsigned FIELDS_PER_REG = 4,
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned DATA_W         = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_LINES-1:0]       rise_i,
  input  logic [NUM_LINES-1:0]       fall_i,
  output logic [NUM_LINES-1:0]       hit_o,
  output logic [NUM_LINES-1:0]       imask_o,
  output logic [NUM_LINES-1:0]       emask_o,
  output logic [NUM_LINES-1:0]       pend_o,
  output logic [NUM_LINES*SEL_W-1:0] sel_o
);
  localparam int unsigned SELR_W  = SEL_W * FIELDS_PER_REG;
  localparam int unsigned NUM_SEL = NUM_LINES / FIELDS_PER_REG;

  logic [NUM_LINES-1:0] imask_q, emask_q, rise_q, fall_q, sw_q, pend_q;
  logic [NUM_LINES*SEL_W-1:0] sel_q;
  logic [NUM_LINES-1:0] clr, sw_set;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  assign clr    = (wr_i && hit_addr(addr_i, OFF_PEND))  ? wdata_i[NUM_LINES-1:0] : '0;
  assign sw_set = (wr_i && hit_addr(addr_i, OFF_SWREQ)) ? wdata_i[NUM_LINES-1:0] : '0;
  assign hit_o  = (rise_i & rise_q) | (fall_i & fall_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      sw_q    <= '0;
      pend_q  <= '0;
      sel_q   <= '0;
    end else begin
      if (wr_i && hit_addr(addr_i, OFF_IMASK)) imask_q <= wdata_i[NUM_LINES-1:0];
      if (wr_i && hit_addr(addr_i, OFF_EMASK)) emask_q <= wdata_i[NUM_LINES-1:0];
      if (wr_i && hit_addr(addr_i, OFF_RISE))  rise_q  <= wdata_i[NUM_LINES-1:0];
      if (wr_i && hit_addr(addr_i, OFF_FALL))  fall_q  <= wdata_i[NUM_LINES-1:0];
      for (int k = 0; k < NUM_SEL; k++) begin
        if (wr_i && hit_addr(addr_i, OFF_SEL0 + REG_STEP*k))
          sel_q[k*SELR_W +: SELR_W] <= wdata_i[SELR_W-1:0];
      end
      // a fresh edge overrides a same-cycle clear
      pend_q <= (pend_q & ~clr) | hit_o | sw_set;
      sw_q   <= (sw_q & ~clr) | sw_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_addr(addr_i, OFF_IMASK)) rdata_o[NUM_LINES-1:0] = imask_q;
    if (hit_addr(addr_i, OFF_EMASK)) rdata_o[NUM_LINES-1:0] = emask_q;
    if (hit_addr(addr_i, OFF_RISE))  rdata_o[NUM_LINES-1:0] = rise_q;
    if (hit_addr(addr_i, OFF_FALL))  rdata_o[NUM_LINES-1:0] = fall_q;
    if (hit_addr(addr_i, OFF_SWREQ)) rdata_o[NUM_LINES-1:0] = sw_q;
    if (hit_addr(addr_i, OFF_PEND))  rdata_o[NUM_LINES-1:0] = pend_q;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (hit_addr(addr_i, OFF_SEL0 + REG_STEP*k))
        rdata_o[SELR_W-1:0] = sel_q[k*SELR_W +: SELR_W];
    end
  end

  assign imask_o = imask_q;
  assign emask_o = emask_q;
  assign pend_o  = pend_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int unsigned NUM_LINES      = 16,
  parameter int unsigned NUM_PORTS      = 7,
  parameter int unsigned SEL_W          = 4,
  parameter int unsigned FIELDS_PER_REG = 4,
  parameter int unsigned DIRECT_LINES   = 5,
  parameter int unsigned SPLIT_LINE     = 10,
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned DATA_W         = 32,
  localparam int unsigned NUM_IRQ       = DIRECT_LINES + 2,
  localparam int unsigned PIN_W         = NUM_PORTS * NUM_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIN_W-1:0]     port_pins_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_IRQ-1:0]   irq_o,
  output logic [NUM_LINES-1:0] event_o
);
  logic [NUM_LINES*SEL_W-1:0] sel;
  logic [NUM_LINES-1:0] line_in, rise, fall, hit, imask, emask, pend, active;
  logic [DATA_W-1:0] reg_rdata;
  logic [NUM_LINES-1:0] evt_q;

  eic_port_mux #(.NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_mux (
    .pins_i(port_pins_i), .sel_i(sel), .line_o(line_in)
  );

  eic_edge_det #(.W(NUM_LINES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(line_in), .rise_o(rise), .fall_o(fall)
  );

  eic_regs #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .FIELDS_PER_REG(FIELDS_PER_REG),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(req_i & we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(reg_rdata), .rise_i(rise), .fall_i(fall),
    .hit_o(hit), .imask_o(imask), .emask_o(emask), .pend_o(pend), .sel_o(sel)
  );

  assign rdata_o = (req_i && !we_i) ? reg_rdata : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= hit & emask;
  end
  assign event_o = evt_q;

  assign active = pend & imask;
  for (genvar i = 0; i < DIRECT_LINES; i++) begin : g_direct
    assign irq_o[i] = active[i];
  end
  assign irq_o[DIRECT_LINES]   = |active[SPLIT_LINE-1:DIRECT_LINES];
  assign irq_o[DIRECT_LINES+1] = |active[NUM_LINES-1:SPLIT_LINE];
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_IRQ   = 7,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [NUM_IRQ-1:0]   irq_o,
  input logic [NUM_LINES-1:0] event_o,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] imask,
  input logic [NUM_LINES-1:0] emask
);
  logic pend_wr, sw_wr;
  assign pend_wr = req_i && we_i && addr_i == ADDR_W'(OFF_PEND);
  assign sw_wr   = req_i && we_i && addr_i == ADDR_W'(OFF_SWREQ);

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_wr |=> ((pend & $past(pend)) == $past(pend))); // R6
  AST_SW_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr |=> ((pend & $past(wdata_i[NUM_LINES-1:0])) == $past(wdata_i[NUM_LINES-1:0]))); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask == '0) |-> (irq_o == '0)); // R5
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> (irq_o == '0)); // R10
  AST_EVT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((event_o & ~$past(emask)) == '0)); // R9
endmodule

bind ext_irq_ctrl eic_checker #(
  .NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .event_o(event_o), .pend(pend),
  .imask(imask), .emask(emask)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [111:0] pins = '0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0] irq;
  logic [15:0] evt;
  int total = 0, bad = 0;

  localparam logic [5:0] A_IM = 6'h00, A_EM = 6'h04, A_RI = 6'h08, A_FA = 6'h0C,
                         A_SW = 6'h10, A_PE = 6'h14, A_S0 = 6'h18;

  // {line[11:8], port[7:5], rise_en, fall_en, imask, exp_after_rise, exp_after_fall}
  localparam logic [11:0] VEC [6] = '{
    {4'd0,  3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd4,  3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd6,  3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'd11, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd15, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd9,  3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  ext_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .port_pins_i(pins), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .event_o(evt)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic set_pin(input int idx, input logic v);
    pins[idx] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int irq_idx(input int ln);
    return (ln < 5) ? ln : (ln < 10) ? 5 : 6;
  endfunction

  task automatic run_vec(input logic [11:0] v);
    int ln = int'(v[11:8]);
    int pt = int'(v[7:5]);
    logic [15:0] bit_m = 16'(1) << ln;
    logic [31:0] rd;
    logic [6:0] exp_irq;
    bus_wr(A_S0 + 6'(4 * (ln / 4)), 32'(pt) << (4 * (ln % 4)));
    bus_wr(A_RI, v[4] ? {16'h0, bit_m} : 32'h0);
    bus_wr(A_FA, v[3] ? {16'h0, bit_m} : 32'h0);
    bus_wr(A_IM, v[2] ? {16'h0, bit_m} : 32'h0);
    set_pin(pt * 16 + ln, 1'b1);
    bus_rd(A_PE, rd);
    check($sformatf("R3 R4 R11 rise pend line %0d", ln), rd, v[1] ? {16'h0, bit_m} : 32'h0);
    exp_irq = (v[2] && v[1]) ? 7'(1 << irq_idx(ln)) : 7'h0;
    check($sformatf("R5 R10 rise irq line %0d", ln), {25'h0, irq}, {25'h0, exp_irq});
    bus_wr(A_PE, 32'hFFFF);
    set_pin(pt * 16 + ln, 1'b0);
    bus_rd(A_PE, rd);
    check($sformatf("R4 R11 fall pend line %0d", ln), rd, v[0] ? {16'h0, bit_m} : 32'h0);
    exp_irq = (v[2] && v[0]) ? 7'(1 << irq_idx(ln)) : 7'h0;
    check($sformatf("R5 R10 fall irq line %0d", ln), {25'h0, irq}, {25'h0, exp_irq});
    bus_wr(A_PE, 32'hFFFF);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {25'h0, irq}, 32'h0);
    check("R1 event", {16'h0, evt}, 32'h0);
    for (int a = 0; a < 10; a++) begin
      bus_rd(6'(4 * a), rd);
      check($sformatf("R1 reg 0x%0h", 4 * a), rd, 32'h0);
    end

    // R2 readback
    bus_wr(A_EM, 32'hFFFF_A5A5);
    bus_rd(A_EM, rd);
    check("R2 event mask readback", rd, 32'h0000_A5A5);
    bus_wr(A_EM, 32'h0);
    bus_wr(6'h24, 32'hFFFF_1234);
    bus_rd(6'h24, rd);
    check("R2 select reg 3 readback", rd, 32'h0000_1234);
    bus_wr(6'h24, 32'h0);
    bus_rd(6'h3C, rd);
    check("R2 unmapped reads zero", rd, 32'h0);

    // table of edge vectors
    for (int i = 0; i < 6; i++) run_vec(VEC[i]);

    // R11 unused port code 9 on line 2
    bus_wr(A_S0, 32'h0000_0900);
    bus_wr(A_RI, 32'h0004);
    bus_wr(A_FA, 32'h0004);
    for (int p = 0; p < 7; p++) pins[p * 16 + 2] = 1'b1;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 7; p++) pins[p * 16 + 2] = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd(A_PE, rd);
    check("R11 unused code never pends", rd, 32'h0);

    // R9 event pulse, interrupt mask clear
    bus_wr(A_S0, 32'h0);
    bus_wr(A_RI, 32'h0002);
    bus_wr(A_FA, 32'h0);
    bus_wr(A_IM, 32'h0);
    bus_wr(A_EM, 32'h0002);
    set_pin(1, 1'b1);
    check("R9 pulse high", {16'h0, evt}, 32'h0002);
    check("R9 R5 irq masked", {25'h0, irq}, 32'h0);
    @(negedge clk);
    check("R9 pulse one cycle", {16'h0, evt}, 32'h0);
    bus_wr(A_PE, 32'hFFFF);
    bus_wr(A_EM, 32'h0);
    pins[1] = 1'b0;
    repeat (4) @(negedge clk);
    pins[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R9 no pulse when event mask clear", {16'h0, evt}, 32'h0);
    bus_rd(A_PE, rd);
    check("R9 R5 pend set without masks", rd, 32'h0002);
    pins[1] = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr(A_PE, 32'hFFFF);

    // R10 shared groups
    bus_wr(A_IM, 32'hFFFF);
    bus_wr(A_RI, 32'h1080);
    pins[7] = 1'b1; pins[12] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 both groups", {25'h0, irq}, 32'h60);
    bus_wr(A_PE, 32'h0080);
    check("R10 group of 5-9 drops", {25'h0, irq}, 32'h40);
    bus_wr(A_PE, 32'hFFFF);
    pins[7] = 1'b0; pins[12] = 1'b0;
    repeat (4) @(negedge clk);

    // R6 write 0 no effect, R8 software request
    bus_wr(A_SW, 32'h0100);
    bus_rd(A_PE, rd);
    check("R8 software sets pend", rd, 32'h0100);
    bus_rd(A_SW, rd);
    check("R8 software bit reads set", rd, 32'h0100);
    check("R8 R10 irq via software", {25'h0, irq}, 32'h20);
    bus_wr(A_PE, 32'h0);
    bus_rd(A_PE, rd);
    check("R6 write zero keeps pend", rd, 32'h0100);
    bus_wr(A_PE, 32'h0100);
    bus_rd(A_PE, rd);
    check("R6 write one clears pend", rd, 32'h0);
    bus_rd(A_SW, rd);
    check("R8 clear drops software bit", rd, 32'h0);

    // R7 edge and clear on the same clock edge
    bus_wr(A_RI, 32'h0008);
    pins[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_wr(A_PE, 32'h0008);
    bus_rd(A_PE, rd);
    check("R7 edge beats clear", rd, 32'h0008);
    bus_wr(A_PE, 32'h0008);
    bus_rd(A_PE, rd);
    check("R7 later clear works", rd, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule